// File: doc/BRIEF.md
# Crystal Startup Trim Sequencer

This block chooses the frequency trim code that a fast crystal oscillator receives while it starts up. It runs on the crystal clock. It counts crystal cycles from the moment the oscillator is enabled, and under one of four programmable policies it steps the applied code through up to three programmed words. The first is a start word, used while the oscillator builds amplitude. The second is an intermediate ramp word. The third is the final word, used in normal operation.

Two status flags come with the applied code. The settled flag reports that enough crystal cycles have passed for the clock to be used by the system. The trim-ready flag reports that the final word is now in effect. The comparator indications are plain inputs that the analog side drives. The register values are static inputs that a register file elsewhere holds.

Top module: `xts_trim_sequencer`

## Requirements
- R1: While `rst` is high, and after it falls with `xtal_en` still low, `settled` is 0. `trim_code` equals `start_trim` in every policy except the fixed policy (`mode_sel` = 2).
- R2: Count policy (`mode_sel` = 0). Call k the number of earlier rising edges of `clk_xtal` since enable at which `xtal_en` was high. The first edge with k equal to `count_thr`×64 switches `trim_code` from `start_trim` to `final_trim`. The code shows on the output right after that edge, so 1 stands for 64 cycles and 63 for 4032.
- R3: In the count policy, a `count_thr` of 0 applies `final_trim` after the first enabled edge.
- R4: Health policy (`mode_sel` = 1). `trim_code` stays at `start_trim` until an edge at which `ramp_ok` is high. From the next cycle on it is `final_trim`.
- R5: Fixed policy (`mode_sel` = 2). `trim_code` equals `final_trim` in every cycle, whether or not `xtal_en` is high.
- R6: Two-step policy (`mode_sel` = 3). `trim_code` starts at `start_trim` and moves to `ramp_trim` after an edge at which `sw1` is high.
- R7: In the two-step policy, an edge at which `sw2` is high moves the code from `ramp_trim` to `final_trim`.
- R8: In the two-step policy, an `sw2` pulse seen before `sw1` is remembered. The code never jumps from start to final directly. It goes to `ramp_trim` on `sw1`, then to `final_trim` one edge later.
- R9: `settled` rises after the first enabled edge with k equal to `settle_thr`×64. It then stays high while `xtal_en` stays high.
- R10: `trim_ready` is high exactly when `trim_code` equals `final_trim`. This includes the case where the start word and the final word are the same value.
- R11: An edge at which `xtal_en` is low clears the cycle count, `settled`, any remembered `sw2`, and the sequence position, so that the start word is applied again.
- R12: While `xtal_en` stays high, the sequence never moves backwards. Once the final word is reached it is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| xtal_en | input | 1 | Oscillator enable; low holds the sequencer at its start |
| mode_sel | input | 2 | Trim policy: 0 count, 1 health, 2 fixed, 3 two-step |
| start_trim | input | TRIM_W | Trim word used first after enable |
| ramp_trim | input | TRIM_W | Intermediate trim word of the two-step policy |
| final_trim | input | TRIM_W | Trim word for normal operation |
| count_thr | input | THR_W | Count-policy switch point in units of 64 cycles |
| settle_thr | input | SETTLE_W | Settle point in units of 64 cycles |
| sw1 | input | 1 | Delay-timeout indication (two-step policy) |
| sw2 | input | 1 | Amplitude-good indication (two-step policy) |
| ramp_ok | input | 1 | Oscillator-ramping indication (health policy) |
| trim_code | output | TRIM_W | Trim code applied now |
| settled | output | 1 | Crystal settle time has elapsed |
| trim_ready | output | 1 | Applied code equals the final word |

## Verification
The bench goes after off-by-one timing at the count and settle boundaries. A design that compares with the wrong sense, or that counts the enabling edge differently, would switch one cycle early or late at exactly 64 or 128 cycles. It also probes an `sw2` pulse that arrives before `sw1`. A design without the remembered pulse would hang on the ramp word, and one that acts on the pulse at once would skip the ramp word. Further cases are a zero count threshold, dropping the enable in the middle of a sequence (a design that kept its count or flag would resume late or report settled wrongly), and a start word equal to the final word, where the ready flag must follow the code value and not the sequence position.

// File: rtl/xts_pkg.sv
package xts_pkg;

    // Position of the startup sequence
    typedef enum logic [1:0] {
        STG_START = 2'd0,
        STG_RAMP  = 2'd1,
        STG_FINAL = 2'd2
    } stage_e;

    // Trim policy as selected by mode_sel
    typedef enum logic [1:0] {
        POL_COUNT    = 2'd0,
        POL_HEALTH   = 2'd1,
        POL_FIXED    = 2'd2,
        POL_TWO_STEP = 2'd3
    } policy_e;

    // Sequencer state: where we are, and whether an early sw2 is held
    typedef struct packed {
        stage_e stage;
        logic   sw2_held;
    } seq_state_t;

    localparam seq_state_t SEQ_IDLE = '{stage: STG_START, sw2_held: 1'b0};

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Counter width that holds the larger threshold scaled by the step, plus headroom
    function automatic int unsigned count_width(input int unsigned thr_w,
                                                input int unsigned settle_w,
                                                input int unsigned step_log2);
        return max_u(thr_w, settle_w) + step_log2 + 1;
    endfunction

endpackage

// File: rtl/xts_cycle_counter.sv
module xts_cycle_counter
    import xts_pkg::*;
#(
    parameter int unsigned THR_W     = 6,
    parameter int unsigned SETTLE_W  = 8,
    parameter int unsigned STEP_LOG2 = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [THR_W-1:0]    count_thr,
    input  logic [SETTLE_W-1:0] settle_thr,
    output logic                count_hit,
    output logic                settled
);
    localparam int unsigned CNT_W = count_width(THR_W, SETTLE_W, STEP_LOG2);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] count_lim;
    logic [CNT_W-1:0] settle_lim;
    logic             settle_hit;

    // Thresholds are in units of 2**STEP_LOG2 cycles: scale by shifting
    assign count_lim  = CNT_W'({count_thr, {STEP_LOG2{1'b0}}});
    assign settle_lim = CNT_W'({settle_thr, {STEP_LOG2{1'b0}}});

    assign count_hit  = (cnt_q >= count_lim);
    assign settle_hit = (cnt_q >= settle_lim);

    // Saturating count of enabled crystal edges
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (cnt_q != {CNT_W{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Sticky settle flag, cleared whenever the oscillator is disabled
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            settled <= 1'b0;
        end else if (settle_hit) begin
            settled <= 1'b1;
        end
    end

endmodule

// File: rtl/xts_stage_fsm.sv
module xts_stage_fsm
    import xts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] mode_sel,
    input  logic       count_hit,
    input  logic       ramp_ok,
    input  logic       sw1,
    input  logic       sw2,
    output stage_e     stage
);
    seq_state_t state_q;
    seq_state_t state_d;
    policy_e    policy;

    assign policy = policy_e'(mode_sel);
    assign stage  = state_q.stage;

    always_comb begin
        state_d = state_q;
        unique case (policy)
            POL_COUNT: begin
                if (count_hit) state_d.stage = STG_FINAL;
            end
            POL_HEALTH: begin
                if (ramp_ok) state_d.stage = STG_FINAL;
            end
            POL_FIXED: begin
                state_d.stage = STG_FINAL;
            end
            POL_TWO_STEP: begin
                unique case (state_q.stage)
                    STG_START: begin
                        // An early sw2 is remembered until ramp has been entered
                        if (sw2) state_d.sw2_held = 1'b1;
                        if (sw1) state_d.stage    = STG_RAMP;
                    end
                    STG_RAMP: begin
                        if (sw2 || state_q.sw2_held) begin
                            state_d.stage    = STG_FINAL;
                            state_d.sw2_held = 1'b0;
                        end
                    end
                    default: state_d = state_q;
                endcase
            end
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/xts_trim_mux.sv
module xts_trim_mux
    import xts_pkg::*;
#(
    parameter int unsigned TRIM_W = 8
) (
    input  logic [1:0]        mode_sel,
    input  stage_e            stage,
    input  logic [TRIM_W-1:0] start_trim,
    input  logic [TRIM_W-1:0] ramp_trim,
    input  logic [TRIM_W-1:0] final_trim,
    output logic [TRIM_W-1:0] trim_code,
    output logic              trim_ready
);
    always_comb begin
        if (policy_e'(mode_sel) == POL_FIXED) begin
            trim_code = final_trim;
        end else begin
            unique case (stage)
                STG_RAMP:  trim_code = ramp_trim;
                STG_FINAL: trim_code = final_trim;
                default:   trim_code = start_trim;
            endcase
        end
    end

    // Ready follows the code value, not the stage
    assign trim_ready = (trim_code == final_trim);

endmodule

// File: rtl/xts_trim_sequencer.sv
module xts_trim_sequencer
    import xts_pkg::*;
#(
    parameter int unsigned TRIM_W    = 8,
    parameter int unsigned THR_W     = 6,
    parameter int unsigned SETTLE_W  = 8,
    parameter int unsigned STEP_LOG2 = 6
) (
    input  logic                clk_xtal,
    input  logic                rst,
    input  logic                xtal_en,
    input  logic [1:0]          mode_sel,
    input  logic [TRIM_W-1:0]   start_trim,
    input  logic [TRIM_W-1:0]   ramp_trim,
    input  logic [TRIM_W-1:0]   final_trim,
    input  logic [THR_W-1:0]    count_thr,
    input  logic [SETTLE_W-1:0] settle_thr,
    input  logic                sw1,
    input  logic                sw2,
    input  logic                ramp_ok,
    output logic [TRIM_W-1:0]   trim_code,
    output logic                settled,
    output logic                trim_ready
);
    logic   count_hit;
    stage_e stage_q;

    xts_cycle_counter #(
        .THR_W     (THR_W),
        .SETTLE_W  (SETTLE_W),
        .STEP_LOG2 (STEP_LOG2)
    ) u_counter (
        .clk        (clk_xtal),
        .rst        (rst),
        .en         (xtal_en),
        .count_thr  (count_thr),
        .settle_thr (settle_thr),
        .count_hit  (count_hit),
        .settled    (settled)
    );

    xts_stage_fsm u_fsm (
        .clk       (clk_xtal),
        .rst       (rst),
        .en        (xtal_en),
        .mode_sel  (mode_sel),
        .count_hit (count_hit),
        .ramp_ok   (ramp_ok),
        .sw1       (sw1),
        .sw2       (sw2),
        .stage     (stage_q)
    );

    xts_trim_mux #(
        .TRIM_W (TRIM_W)
    ) u_mux (
        .mode_sel   (mode_sel),
        .stage      (stage_q),
        .start_trim (start_trim),
        .ramp_trim  (ramp_trim),
        .final_trim (final_trim),
        .trim_code  (trim_code),
        .trim_ready (trim_ready)
    );

endmodule

// File: rtl/xts_trim_sequencer_chk.sv
module xts_trim_sequencer_chk #(
    parameter int unsigned TRIM_W = 8
) (
    input logic              clk_xtal,
    input logic              rst,
    input logic              xtal_en,
    input logic [1:0]        mode_sel,
    input logic [TRIM_W-1:0] trim_code,
    input logic [TRIM_W-1:0] final_trim,
    input logic              trim_ready,
    input logic              settled,
    input logic [1:0]        stage
);
    // R5: the fixed policy always applies the final word and reports ready
    a_r5_fixed_final: assert property (@(posedge clk_xtal) disable iff (rst)
        (mode_sel == 2'd2) |-> (trim_code == final_trim && trim_ready));

    // R9: settled stays high while enable stays high
    a_r9_settled_sticky: assert property (@(posedge clk_xtal) disable iff (rst)
        (settled && xtal_en) |=> settled);

    // R11: an edge without enable clears the settle flag and the stage
    a_r11_disable_clears: assert property (@(posedge clk_xtal) disable iff (rst)
        (!xtal_en) |=> (!settled && stage == 2'd0));

    // R12: the final stage is kept while enabled
    a_r12_final_kept: assert property (@(posedge clk_xtal) disable iff (rst)
        (stage == 2'd2 && xtal_en) |=> (stage == 2'd2));

    // R8: in two-step, the start stage never jumps straight to final
    a_r8_no_skip: assert property (@(posedge clk_xtal) disable iff (rst)
        (stage == 2'd0 && xtal_en && mode_sel == 2'd3) |=> (stage != 2'd2));

endmodule

bind xts_trim_sequencer xts_trim_sequencer_chk #(
    .TRIM_W (TRIM_W)
) u_chk (
    .clk_xtal   (clk_xtal),
    .rst        (rst),
    .xtal_en    (xtal_en),
    .mode_sel   (mode_sel),
    .trim_code  (trim_code),
    .final_trim (final_trim),
    .trim_ready (trim_ready),
    .settled    (settled),
    .stage      (stage_q)
);

// File: tb/test_xts_trim_sequencer.sv
`timescale 1ns/1ps
module test_xts_trim_sequencer;

    logic       clk_xtal = 1'b0;
    logic       rst = 1'b1;
    logic       xtal_en = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic [7:0] start_trim = 8'h3C;
    logic [7:0] ramp_trim = 8'h81;
    logic [7:0] final_trim = 8'hC5;
    logic [5:0] count_thr = 6'd1;
    logic [7:0] settle_thr = 8'd2;
    logic       sw1 = 1'b0;
    logic       sw2 = 1'b0;
    logic       ramp_ok = 1'b0;
    logic [7:0] trim_code;
    logic       settled;
    logic       trim_ready;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state
    int m_k = 0;
    int m_stage = 0;
    bit m_settled = 1'b0;
    bit m_held = 1'b0;

    always #5 clk_xtal = ~clk_xtal;

    xts_trim_sequencer i_xts_trim_sequencer (
        .clk_xtal   (clk_xtal),
        .rst        (rst),
        .xtal_en    (xtal_en),
        .mode_sel   (mode_sel),
        .start_trim (start_trim),
        .ramp_trim  (ramp_trim),
        .final_trim (final_trim),
        .count_thr  (count_thr),
        .settle_thr (settle_thr),
        .sw1        (sw1),
        .sw2        (sw2),
        .ramp_ok    (ramp_ok),
        .trim_code  (trim_code),
        .settled    (settled),
        .trim_ready (trim_ready)
    );

    // Behavioural model of the startup policy, updated on each edge
    always @(posedge clk_xtal) begin
        if (rst || !xtal_en) begin
            m_k = 0; m_stage = 0; m_settled = 1'b0; m_held = 1'b0;
        end else begin
            if (m_k >= int'(settle_thr) * 64) m_settled = 1'b1;
            case (mode_sel)
                2'd0: if (m_k >= int'(count_thr) * 64) m_stage = 2;
                2'd1: if (ramp_ok) m_stage = 2;
                2'd2: m_stage = 2;
                default: begin
                    if (m_stage == 0) begin
                        if (sw2) m_held = 1'b1;
                        if (sw1) m_stage = 1;
                    end else if (m_stage == 1) begin
                        if (sw2 || m_held) begin m_stage = 2; m_held = 1'b0; end
                    end
                end
            endcase
            m_k = m_k + 1;
        end
    end

    function automatic logic [7:0] exp_trim();
        if (mode_sel == 2'd2) return final_trim;
        if (m_stage == 1) return ramp_trim;
        if (m_stage == 2) return final_trim;
        return start_trim;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk_xtal) begin
        if (!done) begin
            chk(trim_code == exp_trim(), cur_req, "trim_code", trim_code, exp_trim());
            chk(settled == m_settled, cur_req, "settled", settled, m_settled);
            chk(trim_ready == (exp_trim() == final_trim), "R10", "trim_ready",
                trim_ready, exp_trim() == final_trim);
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk_xtal);
            #2;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk_xtal);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tick(3);
        chk(trim_code == 8'h3C && !settled, "R1", "reset trim", trim_code, 8'h3C);
        rst = 1'b0;
        tick(2);
        chk(trim_code == 8'h3C && !trim_ready, "R1", "idle trim", trim_code, 8'h3C);

        // R2 / R9: count policy, 64-cycle switch, 128-cycle settle
        cur_req = "R2";
        xtal_en = 1'b1;
        tick(64);
        chk(trim_code == 8'h3C, "R2", "before 64", trim_code, 8'h3C);
        tick(1);
        chk(trim_code == 8'hC5, "R2", "after 64", trim_code, 8'hC5);
        cur_req = "R9";
        tick(63);
        chk(!settled, "R9", "before 128", settled, 0);
        tick(1);
        chk(settled, "R9", "after 128", settled, 1);
        tick(5);

        // R11: disable clears everything
        cur_req = "R11";
        xtal_en = 1'b0;
        tick(1);
        chk(trim_code == 8'h3C && !settled, "R11", "cleared", trim_code, 8'h3C);
        tick(2);

        // R3: zero count threshold, with settle threshold zero (R9)
        cur_req = "R3";
        count_thr = 6'd0;
        settle_thr = 8'd0;
        xtal_en = 1'b1;
        chk(trim_code == 8'h3C, "R3", "before edge", trim_code, 8'h3C);
        tick(1);
        chk(trim_code == 8'hC5, "R3", "after first edge", trim_code, 8'hC5);
        chk(settled, "R9", "zero settle", settled, 1);
        tick(3);
        xtal_en = 1'b0;
        tick(2);

        // R4: health policy
        cur_req = "R4";
        mode_sel = 2'd1;
        settle_thr = 8'd3;
        xtal_en = 1'b1;
        tick(10);
        chk(trim_code == 8'h3C, "R4", "waiting", trim_code, 8'h3C);
        ramp_ok = 1'b1;
        tick(1);
        ramp_ok = 1'b0;
        chk(trim_code == 8'hC5, "R4", "after ramp_ok", trim_code, 8'hC5);
        tick(5);
        chk(trim_code == 8'hC5, "R12", "kept final", trim_code, 8'hC5);
        xtal_en = 1'b0;
        tick(2);

        // R5: fixed policy, disabled and enabled
        cur_req = "R5";
        mode_sel = 2'd2;
        tick(2);
        chk(trim_code == 8'hC5 && trim_ready, "R5", "disabled", trim_code, 8'hC5);
        xtal_en = 1'b1;
        tick(4);
        chk(trim_code == 8'hC5, "R5", "enabled", trim_code, 8'hC5);
        xtal_en = 1'b0;
        tick(2);

        // R6 / R7: two-step, sw1 then sw2
        cur_req = "R6";
        mode_sel = 2'd3;
        xtal_en = 1'b1;
        tick(5);
        sw1 = 1'b1;
        tick(1);
        sw1 = 1'b0;
        chk(trim_code == 8'h81, "R6", "ramp word", trim_code, 8'h81);
        cur_req = "R7";
        tick(4);
        chk(trim_code == 8'h81, "R7", "still ramp", trim_code, 8'h81);
        sw2 = 1'b1;
        tick(1);
        sw2 = 1'b0;
        chk(trim_code == 8'hC5, "R7", "final word", trim_code, 8'hC5);
        tick(3);
        xtal_en = 1'b0;
        tick(2);

        // R8: early sw2 is held until ramp entered
        cur_req = "R8";
        xtal_en = 1'b1;
        tick(2);
        sw2 = 1'b1;
        tick(1);
        sw2 = 1'b0;
        chk(trim_code == 8'h3C, "R8", "no skip", trim_code, 8'h3C);
        tick(3);
        sw1 = 1'b1;
        tick(1);
        sw1 = 1'b0;
        chk(trim_code == 8'h81, "R8", "ramp first", trim_code, 8'h81);
        tick(1);
        chk(trim_code == 8'hC5, "R8", "held sw2 acts", trim_code, 8'hC5);
        tick(2);
        xtal_en = 1'b0;
        tick(2);

        // R10: start word equal to final word reports ready at start
        cur_req = "R10";
        start_trim = 8'hC5;
        xtal_en = 1'b1;
        tick(2);
        chk(trim_ready && trim_code == 8'hC5, "R10", "equal words", trim_ready, 1);
        start_trim = 8'h3C;
        #1;
        chk(!trim_ready, "R10", "words differ", trim_ready, 0);
        tick(2);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule